// File: doc/BRIEF.md
# Byte-Window Memory Access Bridge

This block gives a host that can only issue byte-wide register accesses an indirect path into a 32-bit word memory. It presents eight byte registers in a small window. Two of them are mailboxes, one for each direction between the host and an embedded controller. Two hold an address pointer and an access mode. The other four are data bytes that stage one memory word.

The host first programs the pointer and the mode, then works through the data bytes. In the word modes, reading data byte 0 fetches the addressed word into the staging register, and writing data byte 3 commits the staged word to memory. In the auto-increment mode, touching data byte 3 also moves the pointer on to the next word, so the host can stream through memory four bytes at a time. A byte mode and a half-word mode give narrower accesses.

The internal memory writes on the clock edge, with per-byte enables, and reads combinationally. It holds fewer words than the 15-bit address space can reach, so the upper word-index bits alias onto the stored words. Every host access is a one-cycle strobe. The read result appears on the host read-data port after the next clock edge.

Top module: `bwb_bridge`

## Requirements
- R1: After reset, the pointer, the mode, the staging word, both mailboxes, the mailbox flag and the host read data are all zero.
- R2: Offset 2 is written as {pointer byte-address bits 7:2, mode[1:0]} and reads back the same layout. Offset 3 is written as pointer address bits 14:8 in data bits 6:0, and data bit 7 is ignored. Offset 3 reads back bit 7 as zero. Mode codes: 0 byte, 1 half-word, 2 word, 3 word with auto-increment.
- R3: In modes 2 and 3, a host read of offset 4 (data byte 0) loads the whole addressed word into staging and returns its least significant byte. Reads of offsets 5 to 7 return staging bytes 1 to 3.
- R4: In modes 2 and 3, host writes to offsets 4 to 7 set the matching staging byte. Memory changes only on a write to offset 7, which commits all four staged bytes, with offset 4 as the least significant byte.
- R5: In mode 3, any host read or write of offset 7 advances the pointer by one word after the access. In the other modes, no access changes the pointer.
- R6: The auto-increment wraps from byte address 0x7FFC to 0x0000.
- R7: In mode 0, offset 4+k reads or writes only byte k of the addressed word. It neither loads nor commits the staging word.
- R8: In mode 1, reading offset 4 or 6 loads the low or high half-word into staging and returns the byte at that offset. Reading offset 5 or 7 returns a staging byte. Writing offset 5 or 7 commits the low or high staged half-word.
- R9: A host write to offset 0 sets the host-to-controller mailbox and its sticky flag, and the mailbox can be read at offset 0 and on the controller port. The controller clear input drops the flag. When a host write and a clear fall in the same cycle, the flag ends up set.
- R10: The controller-to-host mailbox is loaded only from the controller port and read at offset 1. Host writes to offset 1 have no effect.
- R11: Host read data is registered and appears one clock edge after the read strobe. Cycles without a host read leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host access is a write when 1 |
| h_off | input | 3 | Register offset within the window |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Registered host read data |
| ec_e2h_we | input | 1 | Controller loads the controller-to-host mailbox |
| ec_e2h_wdata | input | 8 | Controller mailbox write data |
| ec_h2e_clr | input | 1 | Controller clears the host-to-controller flag |
| ec_h2e_data | output | 8 | Host-to-controller mailbox contents |
| ec_h2e_flag | output | 1 | Sticky flag set by a host mailbox write |
| ec_e2h_data | output | 8 | Controller-to-host mailbox contents |

## Verification
A host write to the host-to-controller mailbox and a controller flag clear can land in the same clock cycle. The bench raises both on one cycle and requires the flag to read set afterwards. A separate earlier clear shows that clearing on its own works. The second coincidence is a commit and a pointer advance on the same auto-increment access to data byte 3. The bench writes four consecutive words, then reads them back from a reprogrammed pointer. Each word must sit at its own address, and the final pointer must read back four words on.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        MODE_BYTE     = 2'd0,
        MODE_HALF     = 2'd1,
        MODE_WORD     = 2'd2,
        MODE_WORD_INC = 2'd3
    } acc_mode_e;

    localparam logic [2:0] OFF_H2E   = 3'd0;
    localparam logic [2:0] OFF_E2H   = 3'd1;
    localparam logic [2:0] OFF_ADDR0 = 3'd2;
    localparam logic [2:0] OFF_ADDR1 = 3'd3;
endpackage

// File: rtl/bwb_mailbox.sv
module bwb_mailbox (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       ec_clr,
    input  logic       ec_we,
    input  logic [7:0] ec_wdata,
    output logic [7:0] h2e_data,
    output logic       h2e_flag,
    output logic [7:0] e2h_data
);
    typedef struct packed {
        logic [7:0] h2e;
        logic       flag;
        logic [7:0] e2h;
    } mbox_t;

    mbox_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (host_wr) m_d.h2e = host_wdata;
        // a new host message outranks a clear arriving in the same cycle
        if (host_wr)     m_d.flag = 1'b1;
        else if (ec_clr) m_d.flag = 1'b0;
        if (ec_we) m_d.e2h = ec_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign h2e_data = m_q.h2e;
    assign h2e_flag = m_q.flag;
    assign e2h_data = m_q.e2h;

    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> h2e_flag);
    a_r9_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_clr && !host_wr) |=> !h2e_flag);
    a_r10_e2h_ec_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ec_we |=> $stable(e2h_data));
endmodule

// File: rtl/bwb_wordram.sv
module bwb_wordram #(
    parameter int MEM_AW = 10
) (
    input  logic                            clk,
    input  logic [MEM_AW-1:0]               idx,
    input  logic                            we,
    input  logic [bwb_pkg::WORD_BYTES-1:0]  be,
    input  logic [bwb_pkg::WORD_W-1:0]      wdata,
    output logic [bwb_pkg::WORD_W-1:0]      rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    for (genvar g = 0; g < bwb_pkg::WORD_BYTES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && be[g]) lane_mem[idx] <= wdata[8*g +: 8];
        end
        assign rdata[8*g +: 8] = lane_mem[idx];
    end
endmodule

// File: rtl/bwb_window.sv
module bwb_window
    import bwb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_sel,
    input  logic              h_we,
    input  logic [2:0]        h_off,
    input  logic [7:0]        h_wdata,
    input  logic [7:0]        h2e_val,
    input  logic [7:0]        e2h_val,
    output logic [7:0]        h_rdata,
    output logic [MEM_AW-1:0] mem_idx,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [WORD_BYTES-1:0] mem_be,
    output logic [WORD_W-1:0] mem_wdata
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int HI_W   = ADDR_W - 8;

    typedef struct packed {
        logic [WIDX_W-1:0] widx;
        acc_mode_e         mode;
        logic [WORD_W-1:0] stage;
        logic [7:0]        rdata;
    } win_t;

    win_t s_d, s_q;

    logic       rd, wr;
    logic [1:0] bidx;
    logic [7:0] mem_byte, stage_byte;

    assign rd   = h_sel && !h_we;
    assign wr   = h_sel && h_we;
    assign bidx = h_off[1:0];
    assign mem_byte   = mem_rdata[{bidx, 3'b000} +: 8];
    assign stage_byte = s_q.stage[{bidx, 3'b000} +: 8];

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_be    = '0;
        mem_wdata = s_q.stage;
        if (h_sel && !h_off[2]) begin
            case (h_off)
                OFF_H2E: if (rd) s_d.rdata = h2e_val;
                OFF_E2H: if (rd) s_d.rdata = e2h_val;
                OFF_ADDR0: begin
                    if (wr) begin
                        s_d.widx[5:0] = h_wdata[7:2];
                        s_d.mode      = acc_mode_e'(h_wdata[1:0]);
                    end else begin
                        s_d.rdata = {s_q.widx[5:0], s_q.mode};
                    end
                end
                default: begin
                    if (wr) s_d.widx[WIDX_W-1:6] = h_wdata[HI_W-1:0];
                    else    s_d.rdata = 8'(s_q.widx[WIDX_W-1:6]);
                end
            endcase
        end else if (h_sel) begin
            case (s_q.mode)
                MODE_BYTE: begin
                    if (rd) begin
                        s_d.rdata = mem_byte;
                    end else begin
                        mem_we    = 1'b1;
                        mem_be    = WORD_BYTES'(1) << bidx;
                        mem_wdata = {WORD_BYTES{h_wdata}};
                    end
                end
                MODE_HALF: begin
                    if (rd) begin
                        if (!bidx[0]) begin
                            s_d.stage[{bidx[1], 4'b0000} +: 16] =
                                mem_rdata[{bidx[1], 4'b0000} +: 16];
                            s_d.rdata = mem_byte;
                        end else begin
                            s_d.rdata = stage_byte;
                        end
                    end else begin
                        s_d.stage[{bidx, 3'b000} +: 8] = h_wdata;
                        if (bidx[0]) begin
                            mem_we    = 1'b1;
                            mem_be    = bidx[1] ? 4'b1100 : 4'b0011;
                            mem_wdata = s_d.stage;
                        end
                    end
                end
                default: begin
                    if (rd) begin
                        if (bidx == 2'd0) begin
                            s_d.stage = mem_rdata;
                            s_d.rdata = mem_rdata[7:0];
                        end else begin
                            s_d.rdata = stage_byte;
                        end
                    end else begin
                        s_d.stage[{bidx, 3'b000} +: 8] = h_wdata;
                        if (bidx == 2'd3) begin
                            mem_we    = 1'b1;
                            mem_be    = '1;
                            mem_wdata = s_d.stage;
                        end
                    end
                    if (s_q.mode == MODE_WORD_INC && bidx == 2'd3)
                        s_d.widx = s_q.widx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign h_rdata = s_q.rdata;
    assign mem_idx = s_q.widx[MEM_AW-1:0];

    a_r5_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sel && h_off == 3'd7 && s_q.mode == MODE_WORD_INC)
        |=> s_q.widx == WIDX_W'($past(s_q.widx) + 1'b1));
    a_r5_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sel && h_off[2] && s_q.mode != MODE_WORD_INC) |=> $stable(s_q.widx));
    a_r7_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && s_q.mode == MODE_BYTE) |-> $countones(mem_be) == 1);
    a_r4_full_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && s_q.mode[1]) |-> mem_be == 4'hF);
    a_r2_hi_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && h_off == OFF_ADDR1) |=> !h_rdata[7]);
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(h_rdata));
endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge #(
    parameter int ADDR_W = 15,
    parameter int MEM_AW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_sel,
    input  logic       h_we,
    input  logic [2:0] h_off,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    input  logic       ec_e2h_we,
    input  logic [7:0] ec_e2h_wdata,
    input  logic       ec_h2e_clr,
    output logic [7:0] ec_h2e_data,
    output logic       ec_h2e_flag,
    output logic [7:0] ec_e2h_data
);
    import bwb_pkg::*;

    logic [MEM_AW-1:0]     mem_idx;
    logic [WORD_W-1:0]     mem_rdata, mem_wdata;
    logic                  mem_we;
    logic [WORD_BYTES-1:0] mem_be;
    logic                  host_h2e_wr;

    assign host_h2e_wr = h_sel && h_we && (h_off == OFF_H2E);

    bwb_mailbox u_mbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_h2e_wr),
        .host_wdata(h_wdata),
        .ec_clr    (ec_h2e_clr),
        .ec_we     (ec_e2h_we),
        .ec_wdata  (ec_e2h_wdata),
        .h2e_data  (ec_h2e_data),
        .h2e_flag  (ec_h2e_flag),
        .e2h_data  (ec_e2h_data)
    );

    bwb_window #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_sel    (h_sel),
        .h_we     (h_we),
        .h_off    (h_off),
        .h_wdata  (h_wdata),
        .h2e_val  (ec_h2e_data),
        .e2h_val  (ec_e2h_data),
        .h_rdata  (h_rdata),
        .mem_idx  (mem_idx),
        .mem_rdata(mem_rdata),
        .mem_we   (mem_we),
        .mem_be   (mem_be),
        .mem_wdata(mem_wdata)
    );

    bwb_wordram #(.MEM_AW(MEM_AW)) u_ram (
        .clk  (clk),
        .idx  (mem_idx),
        .we   (mem_we),
        .be   (mem_be),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );
endmodule

// File: tb/sim_bwb_bridge.sv
module sim_bwb_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_sel = 1'b0, h_we = 1'b0;
    logic [2:0] h_off = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       ec_e2h_we = 1'b0;
    logic [7:0] ec_e2h_wdata = '0;
    logic       ec_h2e_clr = 1'b0;
    logic [7:0] ec_h2e_data, ec_e2h_data;
    logic       ec_h2e_flag;

    int n_chk = 0, n_fail = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    bwb_bridge u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_we = 1'b1; h_off = off; h_wdata = d;
        @(negedge clk);
        h_sel = 1'b0; h_we = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_we = 1'b0; h_off = off;
        @(negedge clk);
        h_sel = 1'b0;
        d = h_rdata;
    endtask

    task automatic t_reset;
        chk("R1 rdata", h_rdata, 8'h00);
        chk("R1 flag", {7'd0, ec_h2e_flag}, 8'h00);
        chk("R1 h2e", ec_h2e_data, 8'h00);
        chk("R1 e2h", ec_e2h_data, 8'h00);
        hrd(3'd2, rv); chk("R1 addr0", rv, 8'h00);
        hrd(3'd3, rv); chk("R1 addr1", rv, 8'h00);
    endtask

    task automatic t_addr;
        hwr(3'd2, 8'hAB); hwr(3'd3, 8'hFF);
        hrd(3'd2, rv); chk("R2 addr0 readback", rv, 8'hAB);
        hrd(3'd3, rv); chk("R2 addr1 bit7 ignored", rv, 8'h7F);
    endtask

    task automatic t_word;
        hwr(3'd2, 8'h12); hwr(3'd3, 8'h00);
        hwr(3'd4, 8'h01); hwr(3'd5, 8'h02); hwr(3'd6, 8'h03); hwr(3'd7, 8'h04);
        hwr(3'd4, 8'h11); hwr(3'd5, 8'h22); hwr(3'd6, 8'h33);
        hrd(3'd4, rv); chk("R4 no commit before byte3", rv, 8'h01);
        hrd(3'd5, rv); chk("R3 staged byte1 from load", rv, 8'h02);
        hwr(3'd4, 8'h11); hwr(3'd5, 8'h22); hwr(3'd6, 8'h33); hwr(3'd7, 8'h44);
        hrd(3'd4, rv); chk("R3 load byte0", rv, 8'h11);
        hrd(3'd5, rv); chk("R3 byte1", rv, 8'h22);
        hrd(3'd6, rv); chk("R3 byte2", rv, 8'h33);
        hrd(3'd7, rv); chk("R3 byte3", rv, 8'h44);
        hrd(3'd2, rv); chk("R5 mode2 no increment", rv, 8'h12);
    endtask

    task automatic t_autoinc;
        hwr(3'd2, 8'h23);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 4; b++)
                hwr(3'(4 + b), 8'(16 * k + b + 1));
        hrd(3'd2, rv); chk("R5 pointer after writes", rv, 8'h33);
        hwr(3'd2, 8'h23);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 4; b++) begin
                hrd(3'(4 + b), rv);
                chk("R5 streamed readback", rv, 8'(16 * k + b + 1));
            end
        hrd(3'd2, rv); chk("R5 pointer after reads", rv, 8'h33);
    endtask

    task automatic t_byte;
        hwr(3'd2, 8'h10);
        hrd(3'd5, rv); chk("R7 byte read lane1", rv, 8'h22);
        hwr(3'd6, 8'h99);
        hrd(3'd7, rv); chk("R7 byte read lane3 no load", rv, 8'h44);
        hwr(3'd2, 8'h12);
        hrd(3'd4, rv); chk("R7 lane0 untouched", rv, 8'h11);
        hrd(3'd5, rv); chk("R7 lane1 untouched", rv, 8'h22);
        hrd(3'd6, rv); chk("R7 lane2 written", rv, 8'h99);
        hrd(3'd7, rv); chk("R7 lane3 untouched", rv, 8'h44);
    endtask

    task automatic t_half;
        hwr(3'd2, 8'h11);
        hrd(3'd6, rv); chk("R8 load high half", rv, 8'h99);
        hwr(3'd7, 8'h55);
        hrd(3'd7, rv); chk("R8 staged byte3", rv, 8'h55);
        hwr(3'd4, 8'hAA); hwr(3'd5, 8'hBB);
        hrd(3'd2, rv); chk("R8 no increment", rv, 8'h11);
        hwr(3'd2, 8'h12);
        hrd(3'd4, rv); chk("R8 low commit b0", rv, 8'hAA);
        hrd(3'd5, rv); chk("R8 low commit b1", rv, 8'hBB);
        hrd(3'd6, rv); chk("R8 high kept b2", rv, 8'h99);
        hrd(3'd7, rv); chk("R8 high commit b3", rv, 8'h55);
    endtask

    task automatic t_wrap;
        hwr(3'd2, 8'hFF); hwr(3'd3, 8'h7F);
        hrd(3'd7, rv);
        hrd(3'd2, rv); chk("R6 wrap low", rv, 8'h03);
        hrd(3'd3, rv); chk("R6 wrap high", rv, 8'h00);
    endtask

    task automatic t_mbox;
        hwr(3'd0, 8'h5A);
        chk("R9 ec sees data", ec_h2e_data, 8'h5A);
        chk("R9 flag set", {7'd0, ec_h2e_flag}, 8'h01);
        hrd(3'd0, rv); chk("R9 host readback", rv, 8'h5A);
        hwr(3'd1, 8'h77);
        chk("R11 rdata held on write", h_rdata, 8'h5A);
        @(negedge clk); ec_h2e_clr = 1'b1;
        @(negedge clk); ec_h2e_clr = 1'b0;
        chk("R9 flag cleared", {7'd0, ec_h2e_flag}, 8'h00);
        @(negedge clk);
        h_sel = 1'b1; h_we = 1'b1; h_off = 3'd0; h_wdata = 8'hA5; ec_h2e_clr = 1'b1;
        @(negedge clk);
        h_sel = 1'b0; h_we = 1'b0; ec_h2e_clr = 1'b0;
        chk("R9 set wins over clear", {7'd0, ec_h2e_flag}, 8'h01);
        chk("R9 new data", ec_h2e_data, 8'hA5);
        @(negedge clk); ec_e2h_we = 1'b1; ec_e2h_wdata = 8'hC3;
        @(negedge clk); ec_e2h_we = 1'b0;
        hrd(3'd1, rv); chk("R10 host reads e2h", rv, 8'hC3);
        hwr(3'd1, 8'h00);
        hrd(3'd1, rv); chk("R10 host write ignored", rv, 8'hC3);
        chk("R10 ec view unchanged", ec_e2h_data, 8'hC3);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_addr();
                t_word();
                t_autoinc();
                t_byte();
                t_half();
                t_wrap();
                t_mbox();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule